// File: doc/BRIEF.md
# Credit-Gated Coprocessor Request Admission

This block sits at the coprocessor end of a request channel shared by several main cores. Each request carries one instruction, which may be 32 or 64 bits wide, up to two general-purpose register operand values, the index of the core that sent it, and a retry marker. The block keeps a credit balance for every core. Each credit stands for one queue slot held back for that core. Using these balances, the block decides whether each request is enqueued, recorded for later service, or refused as a protocol violation.

A core starts with no credit, so its first request must carry the retry marker. If the queue has room and no other core is waiting, the block enqueues the instruction and returns one credit to that core. If there is no room, the block records that the core is waiting. When a slot frees, the block sends that core a credit, and the core then resends the same instruction without the marker. An unmarked request always spends one held-back slot and is always enqueued. Accepted entries leave in arrival order through a valid/ready port toward an execution unit.

Top module: `cop_req_admit`

## Requirements
- R1: After reset no core holds credit, no core is recorded as waiting, the queue is empty, no credit pulse is driven and the violation flag is low.
- R2: A marked request is enqueued only when at least two slots are neither occupied nor held back by credits and no core is waiting. The sending core then receives one credit pulse on the cycle after the request.
- R3: A marked request that is not enqueued records its core as waiting. It enqueues nothing and causes no credit pulse for that request.
- R4: When at least one core is waiting and at least one slot is free, one waiting core receives a credit. The core is chosen in round-robin order, starting with the index after the last core served this way (core 0 first after reset), and it is no longer waiting.
- R5: Credits are returned on `crd_valid_o`/`crd_core_o` as pulses, at most one per cycle, one cycle after the decision.
- R6: An unmarked request from a core with a nonzero balance is always enqueued and lowers that core's balance by one.
- R7: An unmarked request from a core with a zero balance is dropped. `proto_err_o` rises on the next cycle and stays high until reset.
- R8: Entries leave in arrival order. An entry is removed on a cycle where `deq_valid_o` and `deq_ready_i` are both high. Its core index, width flag (1 = 64-bit) and operand count travel with it.
- R9: Occupied slots plus outstanding credits never exceed DEPTH. A full reservation produces no further credits until an entry leaves.
- R10: Values the request does not carry read as zero at the output. A 32-bit instruction (width flag 0) has its upper 32 bits cleared. rs1 is cleared when the operand count is 0, and rs2 is cleared when the count is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_core_i | input | IW | Sending core index |
| req_retry_i | input | 1 | Retry marker |
| req_wide_i | input | 1 | 1 = 64-bit instruction, 0 = 32-bit |
| req_nops_i | input | 2 | Number of register operands (0, 1, 2 or more) |
| req_insn_i | input | INSN_W | Instruction word |
| req_rs1_i | input | XLEN | First operand value |
| req_rs2_i | input | XLEN | Second operand value |
| crd_valid_o | output | 1 | Credit pulse |
| crd_core_o | output | IW | Core receiving the credit |
| deq_valid_o | output | 1 | Queue head available |
| deq_ready_i | input | 1 | Execution side takes the head |
| deq_core_o | output | IW | Head core index |
| deq_wide_o | output | 1 | Head width flag |
| deq_nops_o | output | 2 | Head operand count |
| deq_insn_o | output | INSN_W | Head instruction |
| deq_rs1_o | output | XLEN | Head first operand |
| deq_rs2_o | output | XLEN | Head second operand |
| proto_err_o | output | 1 | Sticky protocol violation |

## Verification
A wrong per-core balance shows up at the ports in one of two ways. Either a legal unmarked resend is dropped, raising `proto_err_o` one cycle later, or an illegal one is enqueued and appears on `deq_valid_o` one cycle later. A miscounted reservation shows up as a credit pulse that is missing or extra, on the cycle after the decision. A slipped round-robin pointer changes the `crd_core_o` sequence while waiting cores drain. The reference model is compared on every clock, so each such fault is reported within one to two cycles of the request that exposes it.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  typedef enum logic [2:0] {
    ADM_IDLE,
    ADM_ACCEPT,
    ADM_PARK,
    ADM_SPEND,
    ADM_FAULT
  } adm_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cpa_fifo.sv
module cpa_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = cpa_pkg::idx_w(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> cnt_q < CW'(DEPTH));
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/cpa_rr_pick.sv
module cpa_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = cpa_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  int unsigned c;
  always_comb begin
    grant_o = '0;
    idx_o   = last_i;
    any_o   = 1'b0;
    c       = 0;
    for (int unsigned off = 1; off <= N; off++) begin
      c = (int'(last_i) + off) % N;
      if (!any_o && req_i[c]) begin
        any_o      = 1'b1;
        grant_o[c] = 1'b1;
        idx_o      = IW'(c);
      end
    end
  end
endmodule

// File: rtl/cpa_credit_ledger.sv
module cpa_credit_ledger #(
  parameter int unsigned N = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = cpa_pkg::idx_w(N),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [IW-1:0] inc_idx_i,
  input  logic          dec_i,
  input  logic [IW-1:0] dec_idx_i,
  output logic [N-1:0]  nz_o
);
  for (genvar g = 0; g < N; g++) begin : g_core
    logic [CW-1:0] cnt_q;
    logic inc_hit, dec_hit;
    assign inc_hit = inc_i && (inc_idx_i == IW'(g));
    assign dec_hit = dec_i && (dec_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + CW'(inc_hit) - CW'(dec_hit);
    end
    assign nz_o[g] = (cnt_q != '0);

    assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_hit && !inc_hit |-> cnt_q != '0);
    assert_bal_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(DEPTH));
  end
endmodule

// File: rtl/cop_req_admit.sv
module cop_req_admit #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned INSN_W    = 64,
  parameter int unsigned XLEN      = 64,
  localparam int unsigned IW = cpa_pkg::idx_w(NUM_CORES),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PLW = IW + 1 + 2 + INSN_W + 2 * XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [IW-1:0]     req_core_i,
  input  logic              req_retry_i,
  input  logic              req_wide_i,
  input  logic [1:0]        req_nops_i,
  input  logic [INSN_W-1:0] req_insn_i,
  input  logic [XLEN-1:0]   req_rs1_i,
  input  logic [XLEN-1:0]   req_rs2_i,
  output logic              crd_valid_o,
  output logic [IW-1:0]     crd_core_o,
  output logic              deq_valid_o,
  input  logic              deq_ready_i,
  output logic [IW-1:0]     deq_core_o,
  output logic              deq_wide_o,
  output logic [1:0]        deq_nops_o,
  output logic [INSN_W-1:0] deq_insn_o,
  output logic [XLEN-1:0]   deq_rs1_o,
  output logic [XLEN-1:0]   deq_rs2_o,
  output logic              proto_err_o
);
  import cpa_pkg::*;

  logic [NUM_CORES-1:0] pend_q, pend_d, bal_nz, rr_grant, park_vec;
  logic [IW-1:0]        last_q, rr_idx, crd_idx;
  logic [CW-1:0]        occ, resv_q;
  logic [CW:0]          free_slots;
  logic                 rr_any, any_pend, grant, crd_fire, enq, pop, empty, err_q;
  logic                 crd_v_q;
  logic [IW-1:0]        crd_c_q;
  adm_e                 adm;
  logic [INSN_W-1:0]    insn_m;
  logic [XLEN-1:0]      rs1_m, rs2_m;
  logic [PLW-1:0]       pl_in, pl_out;

  // slots neither holding an entry nor held back by a credit
  assign free_slots = (CW+1)'(DEPTH) - (CW+1)'(occ) - (CW+1)'(resv_q);
  assign any_pend   = |pend_q;

  always_comb begin
    adm = ADM_IDLE;
    if (req_valid_i) begin
      if (req_retry_i)
        adm = (free_slots >= (CW+1)'(2) && !any_pend) ? ADM_ACCEPT : ADM_PARK;
      else
        adm = bal_nz[req_core_i] ? ADM_SPEND : ADM_FAULT;
    end
  end

  cpa_rr_pick #(.N(NUM_CORES)) u_rr (
    .req_i  (pend_q),
    .last_i (last_q),
    .grant_o(rr_grant),
    .idx_o  (rr_idx),
    .any_o  (rr_any)
  );

  assign grant    = (adm != ADM_ACCEPT) && rr_any && (free_slots != '0);
  assign crd_fire = (adm == ADM_ACCEPT) || grant;
  assign crd_idx  = (adm == ADM_ACCEPT) ? req_core_i : rr_idx;
  assign enq      = (adm == ADM_ACCEPT) || (adm == ADM_SPEND);
  assign pop      = deq_ready_i && !empty;

  always_comb begin
    park_vec = '0;
    if (adm == ADM_PARK) park_vec[req_core_i] = 1'b1;
    pend_d = (pend_q & ~(grant ? rr_grant : '0)) | park_vec;
  end

  cpa_credit_ledger #(.N(NUM_CORES), .DEPTH(DEPTH)) u_ledger (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (crd_fire),
    .inc_idx_i(crd_idx),
    .dec_i    (adm == ADM_SPEND),
    .dec_idx_i(req_core_i),
    .nz_o     (bal_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      last_q  <= IW'(NUM_CORES - 1);
      resv_q  <= '0;
      crd_v_q <= 1'b0;
      crd_c_q <= '0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      if (grant) last_q <= rr_idx;
      resv_q  <= resv_q + CW'(crd_fire) - CW'(adm == ADM_SPEND);
      crd_v_q <= crd_fire;
      crd_c_q <= crd_fire ? crd_idx : '0;
      if (adm == ADM_FAULT) err_q <= 1'b1;
    end
  end

  // clear fields the request does not carry
  assign insn_m = req_wide_i ? req_insn_i : {{(INSN_W-32){1'b0}}, req_insn_i[31:0]};
  assign rs1_m  = (req_nops_i != 2'd0) ? req_rs1_i : '0;
  assign rs2_m  = (req_nops_i >= 2'd2) ? req_rs2_i : '0;
  assign pl_in  = {req_core_i, req_wide_i, req_nops_i, insn_m, rs1_m, rs2_m};

  cpa_fifo #(.WIDTH(PLW), .DEPTH(DEPTH)) u_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (enq),
    .data_i (pl_in),
    .pop_i  (pop),
    .data_o (pl_out),
    .count_o(occ),
    .empty_o(empty)
  );

  assign {deq_core_o, deq_wide_o, deq_nops_o, deq_insn_o, deq_rs1_o, deq_rs2_o} = pl_out;
  assign deq_valid_o = !empty;
  assign crd_valid_o = crd_v_q;
  assign crd_core_o  = crd_c_q;
  assign proto_err_o = err_q;

  assert_resv_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW+1)'(occ) + (CW+1)'(resv_q) <= (CW+1)'(DEPTH));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
  assert_grant_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rr_grant));
  assert_grant_waiting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |-> (pend_q & rr_grant) != '0);
  assert_accept_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adm == ADM_ACCEPT) |-> !any_pend && free_slots >= (CW+1)'(2));
endmodule

// File: tb/cop_req_admit_tb.sv
module cop_req_admit_tb;
  localparam int N = 4;
  localparam int DEPTH = 8;

  typedef struct {
    int          core;
    bit          wide;
    int          nops;
    logic [63:0] insn;
    logic [63:0] rs1;
    logic [63:0] rs2;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_retry = 0, req_wide = 0, deq_ready = 0;
  logic [1:0] req_core = 0, req_nops = 0;
  logic [63:0] req_insn = 0, req_rs1 = 0, req_rs2 = 0;
  logic crd_valid, deq_valid, deq_wide, proto_err;
  logic [1:0] crd_core, deq_core, deq_nops;
  logic [63:0] deq_insn, deq_rs1, deq_rs2;

  int n_chk = 0, n_fail = 0;
  int m_cred[N], m_last, m_resv;
  bit m_pend[N], m_err, m_crd_v;
  int m_crd_c;
  ent_t mq[$];
  int seen[$];

  always #10 clk = ~clk;

  cop_req_admit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_core_i(req_core), .req_retry_i(req_retry),
    .req_wide_i(req_wide), .req_nops_i(req_nops), .req_insn_i(req_insn),
    .req_rs1_i(req_rs1), .req_rs2_i(req_rs2),
    .crd_valid_o(crd_valid), .crd_core_o(crd_core),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready),
    .deq_core_o(deq_core), .deq_wide_o(deq_wide), .deq_nops_o(deq_nops),
    .deq_insn_o(deq_insn), .deq_rs1_o(deq_rs1), .deq_rs2_o(deq_rs2),
    .proto_err_o(proto_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit v, input int c, input bit rt, input bit wd,
                            input int nops, input logic [63:0] insn, rs1, rs2, input bit rdy);
    int freec;
    bit anyp;
    int crd;
    bit enq, park;
    ent_t e;
    freec = DEPTH - mq.size() - m_resv;
    anyp = 0;
    for (int k = 0; k < N; k++) if (m_pend[k]) anyp = 1;
    crd = -1; enq = 0; park = 0;
    e.core = c; e.wide = wd; e.nops = nops;
    e.insn = wd ? insn : {32'h0, insn[31:0]};
    e.rs1 = (nops >= 1) ? rs1 : 64'h0;
    e.rs2 = (nops >= 2) ? rs2 : 64'h0;
    if (v) begin
      if (rt) begin
        if (freec >= 2 && !anyp) begin enq = 1; m_cred[c]++; m_resv++; crd = c; end
        else park = 1;
      end else if (m_cred[c] > 0) begin
        enq = 1; m_cred[c]--; m_resv--;
      end else m_err = 1;
    end
    if (crd < 0 && anyp && freec >= 1) begin
      for (int off = 1; off <= N; off++) begin
        int k;
        k = (m_last + off) % N;
        if (crd < 0 && m_pend[k]) begin
          crd = k; m_pend[k] = 0; m_cred[k]++; m_resv++; m_last = k;
        end
      end
    end
    if (park) m_pend[c] = 1;
    if (rdy && mq.size() > 0) void'(mq.pop_front());
    if (enq) mq.push_back(e);
    m_crd_v = (crd >= 0);
    m_crd_c = (crd >= 0) ? crd : 0;
  endtask

  task automatic compare();
    check("R5", crd_valid, m_crd_v);
    if (m_crd_v) check("R5", crd_core, m_crd_c);
    check("R7", proto_err, m_err);
    check("R8", deq_valid, mq.size() > 0);
    if (mq.size() > 0) begin
      check("R8", deq_core, mq[0].core);
      check("R8", deq_wide, mq[0].wide);
      check("R8", deq_nops, mq[0].nops);
      check("R10", deq_insn, mq[0].insn);
      check("R10", deq_rs1, mq[0].rs1);
      check("R10", deq_rs2, mq[0].rs2);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic cycle(input bit v, input int c, input bit rt, input bit wd, input int nops,
                       input logic [63:0] insn, rs1, rs2, input bit rdy);
    req_valid = v; req_core = 2'(c); req_retry = rt; req_wide = wd;
    req_nops = 2'(nops); req_insn = insn; req_rs1 = rs1; req_rs2 = rs2; deq_ready = rdy;
    model_step(v, c, rt, wd, nops, insn, rs1, rs2, rdy);
    @(posedge clk);
    @(negedge clk);
    compare();
    if (crd_valid) seen.push_back(int'(crd_core));
  endtask

  task automatic idle(input bit rdy);
    cycle(0, 0, 0, 0, 0, 64'h0, 64'h0, 64'h0, rdy);
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int pulses;
    for (int k = 0; k < N; k++) begin m_cred[k] = 0; m_pend[k] = 0; end
    m_last = N - 1; m_resv = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in and right after reset
    check("R1", crd_valid, 0);
    check("R1", deq_valid, 0);
    check("R1", proto_err, 0);
    rst_n = 1;
    idle(0);
    check("R1", crd_valid, 0);

    // R2: first marked request with an empty queue
    cycle(1, 0, 1, 1, 2, 64'hAAAA_0001_1111_0001, 64'h11, 64'h22, 0);
    check("R2", crd_valid, 1);
    check("R2", crd_core, 0);
    check("R2", deq_valid, 1);
    // R6 + R10: unmarked resend with the credit, 32-bit, one operand
    cycle(0 + 1, 0, 0, 0, 1, 64'hDEAD_BEEF_0000_0002, 64'h33, 64'h44, 0);
    check("R6", proto_err, 0);
    check("R6", crd_valid, 0);
    // fill: cores 1,2,3 accepted, reservation now full
    cycle(1, 1, 1, 1, 0, 64'h1000, 64'h1, 64'h2, 0);
    cycle(1, 2, 1, 1, 2, 64'h2000, 64'h3, 64'h4, 0);
    cycle(1, 3, 1, 1, 2, 64'h3000, 64'h5, 64'h6, 0);
    check("R2", crd_core, 3);
    // R3: no room, requests are recorded
    cycle(1, 3, 1, 1, 2, 64'h3001, 64'h5, 64'h6, 0);
    check("R3", crd_valid, 0);
    cycle(1, 1, 1, 1, 0, 64'h1001, 64'h0, 64'h0, 0);
    check("R3", crd_valid, 0);
    cycle(1, 0, 1, 1, 0, 64'h0003, 64'h0, 64'h0, 0);
    check("R3", crd_valid, 0);
    // R9: full reservation gives no more credits
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      cycle(1, 2, 1, 1, 0, 64'h2001, 64'h0, 64'h0, 0);
      pulses += crd_valid;
    end
    check("R9", pulses, 0);
    // R4: drain; waiting cores 0..3 served in order after last=3
    seen.delete();
    for (int i = 0; i < 12; i++) idle(1);
    check("R4", seen.size(), 4);
    for (int i = 0; i < 4 && i < seen.size(); i++) check("R4", seen[i], i);
    // resends by every core
    for (int c = 0; c < N; c++) cycle(1, c, 0, 1, 2, 64'h5000 + c, 64'h7, 64'h8, 1);
    check("R6", proto_err, 0);
    for (int i = 0; i < 6; i++) idle(1);

    // random traffic, always legal
    for (int i = 0; i < 4000; i++) begin
      int c, act;
      c = $urandom_range(N - 1);
      act = $urandom_range(9);
      if (act < 3) idle($urandom_range(1));
      else if (m_cred[c] > 0)
        cycle(1, c, 0, $urandom_range(1), $urandom_range(3), {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(3) != 0);
      else
        cycle(1, c, 1, $urandom_range(1), $urandom_range(3), {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(3) != 0);
    end
    for (int i = 0; i < 20; i++) idle(1);
    check("R6", proto_err, 0);

    // R7: spend core 0 to zero, then one more unmarked request
    while (m_cred[0] > 0) cycle(1, 0, 0, 1, 0, 64'h77, 64'h0, 64'h0, 1);
    for (int i = 0; i < 10; i++) idle(1);
    cycle(1, 0, 0, 1, 0, 64'h99, 64'h0, 64'h0, 0);
    check("R7", proto_err, 1);
    check("R7", deq_valid, 0);
    idle(0); idle(1);
    check("R7", proto_err, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule